// File: doc/BRIEF.md
# Dual-Rail Precharge Logic Datapath

This block evaluates a small bitwise function of three single-rail operands inside a dual-rail precharge domain. Each bit is carried as a complementary pair: a true rail and a false rail. An internal phase register alternates every clock between a precharge cycle, in which every rail is held low, and an evaluation cycle, in which exactly one rail of each pair rises. The result is therefore produced with a data-independent number of rising edges per evaluation.

Operands are converted to rail pairs by an encoder that is gated by the phase. The function is built only from non-inverting AND/OR cells: the dual-rail AND drives its true rail with the AND of the true rails and its false rail with the OR of the false rails. Dual-rail OR is the mirror of this. Dual-rail XOR combines both rail pairs. Inversion is a rail swap. A pipeline register captures the evaluated pairs at the end of evaluation and presents an all-low spacer in the following stage's precharge cycle. A decoder turns the registered rails back to a single-rail value and flags malformed pairs. A cell may settle its output as soon as one input decides it (early evaluation). This does not change the logical result.

The function computed per bit is y = (a AND b) XOR (c OR NOT a).

Top module: `dr_precharge_datapath`

## Requirements
- R1: While `phase` is 0 (precharge), both encoded rails of every operand bit are 0. While `phase` is 1 (evaluation), each operand bit has true rail = bit and false rail = its inverse.
- R2: Whenever `y_eval` is 0, every bit of `y_t` and `y_f` is 0.
- R3: Whenever `y_eval` is 1, exactly one of `y_t[i]`, `y_f[i]` is 1 for every bit i, and `y_valid` is 1.
- R4: After reset release, `phase` inverts on every clock edge, and `y_eval` equals the value `phase` had in the previous cycle.
- R5: In a cycle with `y_eval` = 1, `y` equals (a & b) ^ (c | ~a) for the operands present during the preceding evaluation cycle (`phase` = 1).
- R6: `y_err` is 1 only when some bit has both rails high; in operation it stays 0.
- R7: While `rst_n` is low, and until the phase starts toggling, `phase` = 0, `y_eval` = 0, `y_t` = `y_f` = 0 and `y_valid` = 0.
- R8: Operand values applied during a precharge cycle have no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a | input | W | Operand a (single-rail) |
| b | input | W | Operand b (single-rail) |
| c | input | W | Operand c (single-rail) |
| phase | output | 1 | 1 = evaluation, 0 = precharge for the input stage |
| y_t | output | W | Registered true rails of the result |
| y_f | output | W | Registered false rails of the result |
| y_eval | output | 1 | Output stage holds evaluated data |
| y | output | W | Decoded result (true rails) |
| y_valid | output | 1 | Every result pair holds exactly one high rail |
| y_err | output | 1 | Some result pair has both rails high |

## Verification
Operands that count are the ones present in a cycle with `phase` = 1. The result of that cycle appears one clock later, in the cycle in which `phase` has returned to 0 and `y_eval` is 1. The bench drives and samples on the falling edge. In each `phase` = 1 cycle it checks the spacer left from the previous precharge and loads new operands. In the following cycle it checks the decoded value, the one-hot rails and the flags against its own reference function. Random values are driven during every precharge cycle so that R8 is tested by the very next result.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    DR_AND = 2'd0,
    DR_OR  = 2'd1,
    DR_XOR = 2'd2
  } dr_op_e;

  function automatic logic [63:0] dr_ref_fn(input logic [63:0] a,
                                            input logic [63:0] b,
                                            input logic [63:0] c);
    return (a & b) ^ (c | ~a);
  endfunction
endpackage

// File: rtl/dr_enc.sv
module dr_enc #(
  parameter int W = 4
) (
  input  logic         phase,
  input  logic [W-1:0] x,
  output logic [W-1:0] x_t,
  output logic [W-1:0] x_f
);
  // Single-rail side: the inverse is formed before the rails leave the encoder.
  assign x_t = {W{phase}} & x;
  assign x_f = {W{phase}} & ~x;
endmodule

// File: rtl/dr_cell.sv
module dr_cell #(
  parameter int             W  = 4,
  parameter dr_pkg::dr_op_e OP = dr_pkg::DR_AND
) (
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f
);
  // Only AND/OR gates; no inverter on any rail.
  generate
    if (OP == dr_pkg::DR_AND) begin : g_and
      assign q_t = a_t & b_t;
      assign q_f = a_f | b_f;
    end else if (OP == dr_pkg::DR_OR) begin : g_or
      assign q_t = a_t | b_t;
      assign q_f = a_f & b_f;
    end else begin : g_xor
      assign q_t = (a_t & b_f) | (a_f & b_t);
      assign q_f = (a_t & b_t) | (a_f & b_f);
    end
  endgenerate
endmodule

// File: rtl/dr_preg.sv
module dr_preg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cap,
  input  logic [W-1:0] d_t,
  input  logic [W-1:0] d_f,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f,
  output logic         q_eval
);
  logic [W-1:0] nxt_t;
  logic [W-1:0] nxt_f;
  logic         nxt_eval;

  // Capture at the end of evaluation, load the spacer otherwise.
  always_comb begin
    nxt_t    = cap ? d_t : '0;
    nxt_f    = cap ? d_f : '0;
    nxt_eval = cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_t    <= '0;
      q_f    <= '0;
      q_eval <= 1'b0;
    end else if (en) begin
      q_t    <= nxt_t;
      q_f    <= nxt_f;
      q_eval <= nxt_eval;
    end
  end
endmodule

// File: rtl/dr_dec.sv
module dr_dec #(
  parameter int W = 4
) (
  input  logic [W-1:0] r_t,
  input  logic [W-1:0] r_f,
  output logic [W-1:0] y,
  output logic         valid,
  output logic         err
);
  assign y     = r_t;
  assign valid = &(r_t ^ r_f);
  assign err   = |(r_t & r_f);
endmodule

// File: rtl/dr_precharge_datapath.sv
module dr_precharge_datapath #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         phase,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f,
  output logic         y_eval,
  output logic [W-1:0] y,
  output logic         y_valid,
  output logic         y_err
);
  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] sync_q;
  logic                rst_sync;
  logic                phase_q;
  logic                phase_d;

  logic [W-1:0] a_t, a_f, b_t, b_f, c_t, c_f;
  logic [W-1:0] na_t, na_f;
  logic [W-1:0] n1_t, n1_f, n2_t, n2_f, r_t, r_f;

  // Reset: asserted at once, released after SYNC_LEN edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync = sync_q[SYNC_LEN-1];

  // Phase sequencer: 0 = precharge, 1 = evaluation.
  always_comb phase_d = ~phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (rst_sync) phase_q <= phase_d;
  end
  assign phase = phase_q;

  dr_enc #(.W(W)) u_enc_a (.phase(phase_q), .x(a), .x_t(a_t), .x_f(a_f));
  dr_enc #(.W(W)) u_enc_b (.phase(phase_q), .x(b), .x_t(b_t), .x_f(b_f));
  dr_enc #(.W(W)) u_enc_c (.phase(phase_q), .x(c), .x_t(c_t), .x_f(c_f));

  // Logical NOT of a: swap the rails.
  assign na_t = a_f;
  assign na_f = a_t;

  dr_cell #(.W(W), .OP(dr_pkg::DR_AND)) u_and (
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .q_t(n1_t), .q_f(n1_f));
  dr_cell #(.W(W), .OP(dr_pkg::DR_OR)) u_or (
    .a_t(c_t), .a_f(c_f), .b_t(na_t), .b_f(na_f), .q_t(n2_t), .q_f(n2_f));
  dr_cell #(.W(W), .OP(dr_pkg::DR_XOR)) u_xor (
    .a_t(n1_t), .a_f(n1_f), .b_t(n2_t), .b_f(n2_f), .q_t(r_t), .q_f(r_f));

  dr_preg #(.W(W)) u_preg (
    .clk(clk), .rst_n(rst_n), .en(rst_sync), .cap(phase_q),
    .d_t(r_t), .d_f(r_f), .q_t(y_t), .q_f(y_f), .q_eval(y_eval));

  dr_dec #(.W(W)) u_dec (
    .r_t(y_t), .r_f(y_f), .y(y), .valid(y_valid), .err(y_err));
endmodule

// File: rtl/dr_precharge_chk.sv
module dr_precharge_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_sync,
  input logic         phase,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] c,
  input logic [W-1:0] a_t,
  input logic [W-1:0] a_f,
  input logic [W-1:0] y_t,
  input logic [W-1:0] y_f,
  input logic         y_eval,
  input logic [W-1:0] y,
  input logic         y_valid,
  input logic         y_err
);
  a_r1_enc_spacer: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |-> (a_t == '0 && a_f == '0));

  a_r1_enc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> ((a_t ^ a_f) == '1));

  a_r2_out_spacer: assert property (@(posedge clk) disable iff (!rst_n)
    !y_eval |-> (y_t == '0 && y_f == '0 && !y_valid));

  a_r3_out_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    y_eval |-> ((y_t & y_f) == '0 && (y_t | y_f) == '1 && y_valid));

  a_r4_phase_rise: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    !phase |=> phase);

  a_r4_phase_fall: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    phase |=> !phase);

  a_r4_eval_follow: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    phase |=> y_eval);

  a_r5_result: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync)
    y_eval |-> (y == W'(dr_pkg::dr_ref_fn(64'($past(a)), 64'($past(b)), 64'($past(c))))));

  a_r6_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !y_err);

  a_r7_reset_quiet: assert property (@(posedge clk) disable iff (rst_sync)
    (!phase && !y_eval && y_t == '0 && y_f == '0));
endmodule

bind dr_precharge_datapath dr_precharge_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync(rst_sync), .phase(phase),
  .a(a), .b(b), .c(c), .a_t(a_t), .a_f(a_f),
  .y_t(y_t), .y_f(y_f), .y_eval(y_eval), .y(y),
  .y_valid(y_valid), .y_err(y_err));

// File: tb/test_dr_precharge_datapath.sv
module test_dr_precharge_datapath;
  localparam int W = 4;
  localparam int N_EVAL = 300;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic         phase, y_eval, y_valid, y_err;
  logic [W-1:0] y_t, y_f, y;

  int checks = 0;
  int errors = 0;
  int early  = 0;

  dr_precharge_datapath #(.W(W)) i_dr_precharge_datapath (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c), .phase(phase),
    .y_t(y_t), .y_f(y_f), .y_eval(y_eval), .y(y),
    .y_valid(y_valid), .y_err(y_err));

  always #2 clk = ~clk;

  function automatic logic [W-1:0] ref_y(logic [W-1:0] x, logic [W-1:0] z, logic [W-1:0] w);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (x[i] && z[i]) != (w[i] || !x[i]);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired: actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [W-1:0] exp_y;
    logic [W-1:0] da [4];
    logic [W-1:0] db [4];
    logic [W-1:0] dc [4];
    logic         prev_phase;
    void'($urandom(32'd1357));
    da = '{4'h0, 4'hF, 4'hF, 4'hA};
    db = '{4'h0, 4'hF, 4'h0, 4'h5};
    dc = '{4'h0, 4'hF, 4'h0, 4'h3};

    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 phase", phase, 0);
    chk("R7 y_eval", y_eval, 0);
    chk("R7 rails", {y_t, y_f}, 0);
    chk("R7 y_valid", y_valid, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R7 quiet after release", {phase, y_eval, y_t, y_f}, 0);
    while (phase !== 1'b1) @(negedge clk);

    prev_phase = 1'b0;
    for (int k = 0; k < N_EVAL; k++) begin
      // Evaluation cycle: spacer still at the output, load real operands.
      chk("R4 phase rises", {prev_phase, phase}, 2'b01);
      chk("R2 spacer y_t/y_f", {y_eval, y_t, y_f}, 0);
      chk("R2 no valid in spacer", y_valid, 0);
      if (k < 4) begin
        a = da[k]; b = db[k]; c = dc[k];
      end else begin
        a = W'($urandom); b = W'($urandom); c = W'($urandom);
      end
      exp_y = ref_y(a, b, c);
      if ((~a | ~b) != '0) early++;
      @(negedge clk);
      // Result cycle (precharge for the input stage).
      chk("R4 phase falls", phase, 0);
      chk("R4 y_eval follows", y_eval, 1);
      chk("R5 result", y, exp_y);
      chk("R3 one rail per bit", {y_t & y_f, y_t | y_f}, {{W{1'b0}}, {W{1'b1}}});
      chk("R3 y_valid", y_valid, 1);
      chk("R6 y_err", y_err, 0);
      // R8: garbage in precharge must not reach the next result.
      a = ~a ^ W'($urandom); b = W'($urandom); c = ~c;
      prev_phase = phase;
      @(negedge clk);
    end
    $display("Early-decidable AND evaluations recorded: %0d", early);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule